// File: doc/BRIEF.md
# Multimedia Integer Difference and Average Unit

This block is a single-stage integer execution unit for audio and video kernels. Each accepted operation takes two source operands and returns one result. The operations are a rounding average, an absolute difference (signed or unsigned), an absolute difference added into a running total (signed or unsigned), and minimum and maximum (signed or unsigned). The running-total forms are the building block of sum-of-absolute-differences loops: the caller passes in the prior destination value and receives the new total.

An issue slot presents an opcode, both operands, the prior destination value, a record-enable bit and a summary-overflow bit, all qualified by `in_valid`. Exactly one clock later the unit presents the result with `out_valid`. When the record-enable bit is set, it also presents a 4-bit condition field derived from that result. Opcodes with no assigned meaning return zero and raise a flag.

Top module: `mm_alu`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid`, `out_rt`, `out_cr`, `out_cr_we` and `out_illegal` are all zero.
- R2: A result appears with `out_valid` high on the clock edge that follows the edge at which `in_valid` was sampled high. `out_valid` is low on the cycle after an edge at which `in_valid` was low.
- R3: Opcode 0 (average) returns (RA + RB + 1) >> 1, computed as unsigned values one bit wider than the operands, so that no carry is lost. Two all-ones operands return all-ones.
- R4: Opcode 1 returns the absolute difference of RA and RB taken as two's-complement numbers, modulo 2^XLEN. For example, the most negative value against the most positive value gives all-ones.
- R5: Opcode 2 returns the absolute difference of RA and RB taken as unsigned numbers.
- R6: Opcodes 3 (signed) and 4 (unsigned) return the prior destination input plus the matching absolute difference. The sum wraps modulo 2^XLEN and does not saturate.
- R7: Opcode 5 (signed) and opcode 6 (unsigned) return RA when RA is less than RB, and RB otherwise.
- R8: Opcode 7 (signed) and opcode 8 (unsigned) return RA when RA is greater than RB, and RB otherwise.
- R9: With the record bit set, `out_cr_we` is 1 and `out_cr` holds, from bit 3 down to bit 0: the result is negative as a signed value; the result is positive and nonzero; the result is zero; and a copy of `in_so`.
- R10: With the record bit clear, `out_cr_we` is 0 and `out_cr` is 0 whatever the value of `in_so`.
- R11: Opcodes 9 to 15 return a zero result with `out_illegal` = 1. Opcodes 0 to 8 return `out_illegal` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| in_op | input | 4 | Opcode |
| in_ra | input | XLEN | First source operand |
| in_rb | input | XLEN | Second source operand |
| in_rt | input | XLEN | Prior destination value, used by the accumulate opcodes |
| in_rc | input | 1 | Record-enable: update the condition field |
| in_so | input | 1 | Summary-overflow bit copied into the condition field |
| out_valid | output | 1 | Result valid |
| out_rt | output | XLEN | Result |
| out_cr | output | 4 | Condition field {negative, positive, zero, overflow copy} |
| out_cr_we | output | 1 | Condition field is to be written |
| out_illegal | output | 1 | Opcode had no assigned meaning |

## Verification
The bench builds the unit with XLEN = 64, the width of the target register file. At this width the signed and unsigned orderings disagree whenever bit 63 differs between the operands. The directed cases therefore place operands on both sides of that bit: the most negative and most positive values, and all-ones against zero. They also reach the carry out of bit 63, both in the average sum and in an accumulate that wraps past all-ones. Random operands, opcodes across the full 4-bit range, and random record and overflow bits cover the remaining mix.

// File: rtl/mm_alu_pkg.sv
package mm_alu_pkg;

    typedef enum logic [3:0] {
        OP_AVG    = 4'd0,
        OP_ABS_S  = 4'd1,
        OP_ABS_U  = 4'd2,
        OP_ACC_S  = 4'd3,
        OP_ACC_U  = 4'd4,
        OP_MIN_S  = 4'd5,
        OP_MIN_U  = 4'd6,
        OP_MAX_S  = 4'd7,
        OP_MAX_U  = 4'd8
    } op_e;

    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
        logic ovf;
    } cond_t;

    typedef struct packed {
        logic  legal;
        logic  use_signed;
        logic  is_avg;
        logic  is_abs;
        logic  is_acc;
        logic  is_min;
        logic  is_max;
    } dec_t;

    function automatic dec_t decode_op(input logic [3:0] code);
        dec_t d;
        d = '0;
        d.legal = 1'b1;
        case (code)
            4'd0: d.is_avg = 1'b1;
            4'd1: begin d.is_abs = 1'b1; d.use_signed = 1'b1; end
            4'd2: d.is_abs = 1'b1;
            4'd3: begin d.is_abs = 1'b1; d.is_acc = 1'b1; d.use_signed = 1'b1; end
            4'd4: begin d.is_abs = 1'b1; d.is_acc = 1'b1; end
            4'd5: begin d.is_min = 1'b1; d.use_signed = 1'b1; end
            4'd6: d.is_min = 1'b1;
            4'd7: begin d.is_max = 1'b1; d.use_signed = 1'b1; end
            4'd8: d.is_max = 1'b1;
            default: d.legal = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mm_cmp.sv
module mm_cmp #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         use_signed,
    output logic         lt,
    output logic         eq
);
    logic lt_u;
    logic sign_differs;

    always_comb begin
        lt_u         = (a < b);
        sign_differs = a[W-1] ^ b[W-1];
        eq           = (a == b);
        if (use_signed && sign_differs)
            lt = a[W-1];
        else
            lt = lt_u;
    end
endmodule

// File: rtl/mm_absdiff.sv
module mm_absdiff #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_lt_b,
    output logic [W-1:0] diff
);
    logic [W-1:0] minuend;
    logic [W-1:0] subtrahend;

    always_comb begin
        if (a_lt_b) begin
            minuend    = b;
            subtrahend = a;
        end else begin
            minuend    = a;
            subtrahend = b;
        end
        diff = (~subtrahend) + minuend + W'(1);
    end
endmodule

// File: rtl/mm_crgen.sv
module mm_crgen
    import mm_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] res,
    input  logic         so,
    input  logic         enable,
    output cond_t        cr
);
    logic is_zero;

    always_comb begin
        is_zero = (res == '0);
        cr      = '0;
        if (enable) begin
            cr.neg  = res[W-1];
            cr.pos  = !res[W-1] && !is_zero;
            cr.zero = is_zero;
            cr.ovf  = so;
        end
    end
endmodule

// File: rtl/mm_alu.sv
module mm_alu
    import mm_alu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [3:0]      in_op,
    input  logic [XLEN-1:0] in_ra,
    input  logic [XLEN-1:0] in_rb,
    input  logic [XLEN-1:0] in_rt,
    input  logic            in_rc,
    input  logic            in_so,
    output logic            out_valid,
    output logic [XLEN-1:0] out_rt,
    output logic [3:0]      out_cr,
    output logic            out_cr_we,
    output logic            out_illegal
);
    localparam int SUMW = XLEN + 1;

    dec_t            dec;
    logic            a_lt_b;
    logic            a_eq_b;
    logic [XLEN-1:0] abs_diff;
    logic [SUMW-1:0] avg_sum;
    logic [XLEN-1:0] result;
    cond_t           cr_next;

    assign dec = decode_op(in_op);

    mm_cmp #(.W(XLEN)) u_cmp (
        .a          (in_ra),
        .b          (in_rb),
        .use_signed (dec.use_signed),
        .lt         (a_lt_b),
        .eq         (a_eq_b)
    );

    mm_absdiff #(.W(XLEN)) u_abs (
        .a      (in_ra),
        .b      (in_rb),
        .a_lt_b (a_lt_b),
        .diff   (abs_diff)
    );

    always_comb begin
        avg_sum = {1'b0, in_ra} + {1'b0, in_rb} + SUMW'(1);
        result  = '0;
        if (dec.is_avg)
            result = avg_sum[SUMW-1:1];
        else if (dec.is_abs)
            result = dec.is_acc ? (in_rt + abs_diff) : abs_diff;
        else if (dec.is_min)
            result = a_lt_b ? in_ra : in_rb;
        else if (dec.is_max)
            result = (!a_lt_b && !a_eq_b) ? in_ra : in_rb;
    end

    mm_crgen #(.W(XLEN)) u_cr (
        .res    (result),
        .so     (in_so),
        .enable (in_rc),
        .cr     (cr_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_rt      <= '0;
            out_cr      <= '0;
            out_cr_we   <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_rt      <= result;
                out_cr      <= cr_next;
                out_cr_we   <= in_rc;
                out_illegal <= !dec.legal;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_rt == '0)); // R11
    AST_CR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_cr_we) |-> (out_cr == 4'd0)); // R10
    AST_CR_ONE_SIGN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cr_we) |-> ($countones(out_cr[3:1]) == 1)); // R9
    AST_SO_COPY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_rc) |=> (out_cr[0] == $past(in_so))); // R9
endmodule

// File: tb/tb_mm_alu.sv
module tb_mm_alu;
    localparam int XLEN = 64;
    localparam logic [XLEN-1:0] ONES = '1;
    localparam logic [XLEN-1:0] SMIN = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] SMAX = {1'b0, {(XLEN-1){1'b1}}};

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic [3:0]      in_op;
    logic [XLEN-1:0] in_ra, in_rb, in_rt;
    logic            in_rc, in_so;
    logic            out_valid;
    logic [XLEN-1:0] out_rt;
    logic [3:0]      out_cr;
    logic            out_cr_we;
    logic            out_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mm_alu #(.XLEN(XLEN)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_ra(in_ra), .in_rb(in_rb), .in_rt(in_rt), .in_rc(in_rc),
        .in_so(in_so), .out_valid(out_valid), .out_rt(out_rt),
        .out_cr(out_cr), .out_cr_we(out_cr_we), .out_illegal(out_illegal)
    );

    function automatic logic [XLEN-1:0] absd(input logic [XLEN-1:0] a,
                                             input logic [XLEN-1:0] b,
                                             input bit sgn);
        bit less;
        less = sgn ? ($signed(a) < $signed(b)) : (a < b);
        return less ? (b - a) : (a - b);
    endfunction

    function automatic logic [XLEN-1:0] model(input logic [3:0] op,
                                              input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b,
                                              input logic [XLEN-1:0] t);
        logic [XLEN:0] s;
        case (op)
            4'd0: begin s = {1'b0, a} + {1'b0, b} + 1; return s[XLEN:1]; end
            4'd1: return absd(a, b, 1'b1);
            4'd2: return absd(a, b, 1'b0);
            4'd3: return t + absd(a, b, 1'b1);
            4'd4: return t + absd(a, b, 1'b0);
            4'd5: return ($signed(a) < $signed(b)) ? a : b;
            4'd6: return (a < b) ? a : b;
            4'd7: return ($signed(a) > $signed(b)) ? a : b;
            4'd8: return (a > b) ? a : b;
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2: return "R5";
            4'd3, 4'd4: return "R6";
            4'd5, 4'd6: return "R7";
            4'd7, 4'd8: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic [XLEN-1:0] a,
                          input logic [XLEN-1:0] b, input logic [XLEN-1:0] t,
                          input logic rc, input logic so);
        logic [XLEN-1:0] e;
        logic [3:0]      ecr;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_ra = a; in_rb = b; in_rt = t;
        in_rc = rc; in_so = so;
        e = model(op, a, b, t);
        ecr = rc ? {e[XLEN-1], !e[XLEN-1] && (e != 0), e == 0, so} : 4'd0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", XLEN'(out_valid), XLEN'(1));
        check(req_of(op), out_rt, e);
        check(rc ? "R9" : "R10", XLEN'({out_cr_we, out_cr}), XLEN'({rc, ecr}));
        check("R11", XLEN'(out_illegal), XLEN'(op > 4'd8));
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b1; in_op = '0; in_ra = ONES; in_rb = ONES;
        in_rt = '0; in_rc = 1'b1; in_so = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset
        check("R1", XLEN'({out_valid, out_cr_we, out_illegal, out_cr}), '0);
        check("R1", out_rt, '0);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", XLEN'(out_valid), '0);
        check("R2", XLEN'(out_valid), '0);

        run_op(4'd0, ONES, ONES, '0, 1'b1, 1'b0);   // R3 carry kept
        run_op(4'd0, 64'd3, 64'd4, '0, 1'b0, 1'b1); // R3 round up
        run_op(4'd1, SMIN, SMAX, '0, 1'b1, 1'b0);   // R4 wrap
        run_op(4'd2, SMIN, SMAX, '0, 1'b1, 1'b1);   // R5
        run_op(4'd1, 64'd5, 64'd5, '0, 1'b1, 1'b0); // R4 equal, R9 zero
        run_op(4'd4, 64'd1, 64'd3, ONES, 1'b0, 1'b0); // R6 wrap
        run_op(4'd3, ONES, 64'd1, 64'd10, 1'b1, 1'b0); // R6 signed
        run_op(4'd5, ONES, 64'd0, '0, 1'b1, 1'b0);  // R7 signed
        run_op(4'd6, ONES, 64'd0, '0, 1'b1, 1'b0);  // R7 unsigned
        run_op(4'd7, ONES, 64'd0, '0, 1'b1, 1'b0);  // R8 signed
        run_op(4'd8, ONES, 64'd0, '0, 1'b0, 1'b1);  // R8 unsigned, R10
        run_op(4'd7, 64'd7, 64'd7, '0, 1'b1, 1'b1); // R8 equal
        run_op(4'd9, ONES, 64'd2, '0, 1'b1, 1'b1);  // R11
        run_op(4'd15, 64'd1, 64'd2, '0, 1'b0, 1'b0); // R11
        @(negedge clk);
        check("R2", XLEN'(out_valid), '0);

        for (int i = 0; i < 300; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            if (i % 3 == 0) op = 4'($urandom_range(0, 8));
            run_op(op, {$urandom, $urandom}, {$urandom, $urandom},
                   {$urandom, $urandom}, 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule